// File: doc/BRIEF.md
# PWM Counter Event Interrupt and Trigger Generator

This block holds the timebase counter of a pulse-width modulator and turns selected counter events into two kinds of output: a sticky interrupt request and a single-cycle pulse meant to start a data converter. Six events are watched. Two are the counter reaching zero and reaching its load value. The other four come from the two compare values, A and B. Each compare value has one event for a match while the counter rises and a separate event for a match while it falls.

A 32-bit enable word chooses which events reach the interrupt path and which reach the trigger path. The two choices are independent, and any mix of the six events is allowed. Interrupt events latch into per-event status bits. Software clears these bits by writing ones to them. The trigger is a plain pulse and keeps no record of which event caused it. The counter sweeps from zero up to the load value and back down. A mode input can switch it to a count-down-only sawtooth instead.

Top module: `pwm_event_gen`

## Requirements
- R1: After reset the counter is 0 and its direction flag `cnt_up` is 1. In up/down mode (`mode_down`=0) with load L>0, each step with `run`=1 moves the counter one place along the sequence 0,1,..,L,L-1,..,1,0,1,... The flag `cnt_up` is 1 exactly when the next step goes upward, so it is 0 at L and 1 at 0. With L=0 the counter stays at 0 and `cnt_up` stays 1.
- R2: In count-down-only mode (`mode_down`=1), `cnt_up` reads 0. Each step decrements the counter by one. A step taken at 0 reloads the counter with the load value.
- R3: While `run` is 0, the counter and the direction flag hold their values. No event occurs, so neither `trig` nor `raw_sts` changes.
- R4: On a step with `run`=1, the six events are decided from the counter value and `cnt_up` present before the clock edge. The events are indexed as follows: 0 = counter is 0, 1 = counter equals the load value, 2 = equals A with `cnt_up`=1, 3 = equals A with `cnt_up`=0, 4 = equals B with `cnt_up`=1, 5 = equals B with `cnt_up`=0. A compare value of 0 or of the load value still raises the up or down event that matches `cnt_up` on that step.
- R5: Bits 5:0 of the enable word are the interrupt enables for events 0 to 5, with bit i enabling event i.
- R6: Bits 13:8 of the enable word are the trigger enables, with bit 8+i enabling event i.
- R7: The enable word resets to 0. A write with `cfg_we`=1 takes effect at the clock edge, and `cfg_rdata` shows it from the next cycle. Bits 31:14 and 7:6 always read 0, and writes to them are ignored.
- R8: `trig` is high for the one cycle after a step in which at least one trigger-enabled event occurs. It is high for exactly one cycle per such step, however many of those events coincide.
- R9: An event that is interrupt-enabled sets bit i of `raw_sts` at that edge. The bit stays set until a cycle with `sts_clr_we`=1 and `sts_clr[i]`=1 clears it. A new event in the same cycle as the clear wins, and the bit stays set.
- R10: `irq` is high exactly when some bit i is set both in `raw_sts` and in interrupt enable bit i. Clearing an enable drops `irq` but leaves `raw_sts` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Counter step enable |
| mode_down | input | 1 | 1 = count-down-only, 0 = up/down |
| load_val | input | CNT_W | Load (period) value |
| cmp_a | input | CNT_W | Compare value A |
| cmp_b | input | CNT_W | Compare value B |
| cfg_we | input | 1 | Enable word write strobe |
| cfg_wdata | input | 32 | Enable word write data |
| cfg_rdata | output | 32 | Enable word read data |
| sts_clr_we | input | 1 | Status clear strobe |
| sts_clr | input | 6 | Write-one-to-clear mask for `raw_sts` |
| raw_sts | output | 6 | Latched interrupt event status |
| irq | output | 1 | Interrupt request |
| trig | output | 1 | Converter trigger pulse |
| cnt | output | CNT_W | Counter value |
| cnt_up | output | 1 | Counter direction flag |

## Verification
Every result is one register away from the step that causes it. The bench drives inputs at a falling edge and lets one rising edge pass. At the next falling edge it compares `cnt`, `cnt_up`, `trig` and `raw_sts` against the values its arithmetic model predicts for that step. `irq` and `cfg_rdata` follow the registered state with no further delay, so they are checked at the same falling edge. The sweep covers every load value from 0 to 5, every position of A, B set to its mirror position, both counting modes, and three enable patterns. A full-mask clear arrives on every fourth step, so clears regularly coincide with new events.

// File: rtl/pwm_evt_pkg.sv
package pwm_evt_pkg;
    localparam int NUM_EV  = 6;
    localparam int NUM_CMP = 2;
    localparam int CFG_W   = 32;
    localparam int INT_LSB = 0;
    localparam int TRG_LSB = 8;

    // event indices; the enable fields decode these positions
    localparam int EV_ZERO = 0;
    localparam int EV_LOAD = 1;
    localparam int EV_CMP0 = 2;  // first compare, up; +1 is down; +2 per compare
endpackage

// File: rtl/pwm_evt_counter.sv
module pwm_evt_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             mode_down,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             cnt_up
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam logic [CNT_W:0]   EXT_ONE = (CNT_W+1)'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             up;
    } ctr_t;

    ctr_t st_d, st_q;
    logic [CNT_W:0] inc_w;

    always_comb begin
        st_d  = st_q;
        inc_w = {1'b0, st_q.cnt} + EXT_ONE;
        if (run) begin
            if (mode_down) begin
                st_d.up = 1'b0;
                if (st_q.cnt == '0) begin
                    st_d.cnt = load_val;
                end else begin
                    st_d.cnt = st_q.cnt - CNT_ONE;
                end
            end else if (load_val == '0) begin
                st_d.cnt = '0;
                st_d.up  = 1'b1;
            end else if (st_q.up) begin
                if (inc_w >= {1'b0, load_val}) begin
                    st_d.cnt = load_val;
                    st_d.up  = 1'b0;
                end else begin
                    st_d.cnt = inc_w[CNT_W-1:0];
                end
            end else begin
                if (st_q.cnt <= CNT_ONE) begin
                    st_d.cnt = '0;
                    st_d.up  = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt - CNT_ONE;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0, up: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt    = st_q.cnt;
    assign cnt_up = st_q.up & ~mode_down;
endmodule

// File: rtl/pwm_evt_detect.sv
module pwm_evt_detect
    import pwm_evt_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic                            run,
    input  logic [CNT_W-1:0]                cnt,
    input  logic                            cnt_up,
    input  logic [CNT_W-1:0]                load_val,
    input  logic [NUM_CMP-1:0][CNT_W-1:0]   cmp_val,
    output logic [NUM_EV-1:0]               ev
);
    logic [NUM_CMP-1:0] hit;

    assign ev[EV_ZERO] = run & (cnt == '0);
    assign ev[EV_LOAD] = run & (cnt == load_val);

    for (genvar c = 0; c < NUM_CMP; c++) begin : g_cmp
        assign hit[c]              = run & (cnt == cmp_val[c]);
        assign ev[EV_CMP0 + 2*c]   = hit[c] &  cnt_up;
        assign ev[EV_CMP0 + 2*c+1] = hit[c] & ~cnt_up;
    end
endmodule

// File: rtl/pwm_evt_ctrl.sv
module pwm_evt_ctrl
    import pwm_evt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_EV-1:0] ev,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_rdata,
    input  logic              sts_clr_we,
    input  logic [NUM_EV-1:0] sts_clr,
    output logic [NUM_EV-1:0] raw_sts,
    output logic              irq,
    output logic              trig
);
    typedef struct packed {
        logic [NUM_EV-1:0] ien;
        logic [NUM_EV-1:0] ten;
        logic [NUM_EV-1:0] sts;
        logic              trig;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic [NUM_EV-1:0] clr_mask;

    always_comb begin
        ctl_d    = ctl_q;
        clr_mask = sts_clr_we ? sts_clr : '0;
        if (cfg_we) begin
            ctl_d.ien = cfg_wdata[INT_LSB +: NUM_EV];
            ctl_d.ten = cfg_wdata[TRG_LSB +: NUM_EV];
        end
        // a fresh event beats a simultaneous clear
        ctl_d.sts  = (ctl_q.sts & ~clr_mask) | (ev & ctl_q.ien);
        ctl_d.trig = |(ev & ctl_q.ten);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        cfg_rdata = '0;
        cfg_rdata[INT_LSB +: NUM_EV] = ctl_q.ien;
        cfg_rdata[TRG_LSB +: NUM_EV] = ctl_q.ten;
    end

    assign raw_sts = ctl_q.sts;
    assign irq     = |(ctl_q.sts & ctl_q.ien);
    assign trig    = ctl_q.trig;
endmodule

// File: rtl/pwm_event_gen.sv
module pwm_event_gen
    import pwm_evt_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              mode_down,
    input  logic [CNT_W-1:0]  load_val,
    input  logic [CNT_W-1:0]  cmp_a,
    input  logic [CNT_W-1:0]  cmp_b,
    input  logic              cfg_we,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              sts_clr_we,
    input  logic [5:0]        sts_clr,
    output logic [5:0]        raw_sts,
    output logic              irq,
    output logic              trig,
    output logic [CNT_W-1:0]  cnt,
    output logic              cnt_up
);
    logic [NUM_CMP-1:0][CNT_W-1:0] cmp_val;
    logic [NUM_EV-1:0]             ev;

    assign cmp_val[0] = cmp_a;
    assign cmp_val[1] = cmp_b;

    pwm_evt_counter #(.CNT_W(CNT_W)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .mode_down (mode_down),
        .load_val  (load_val),
        .cnt       (cnt),
        .cnt_up    (cnt_up)
    );

    pwm_evt_detect #(.CNT_W(CNT_W)) u_det (
        .run      (run),
        .cnt      (cnt),
        .cnt_up   (cnt_up),
        .load_val (load_val),
        .cmp_val  (cmp_val),
        .ev       (ev)
    );

    pwm_evt_ctrl u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev         (ev),
        .cfg_we     (cfg_we),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .sts_clr_we (sts_clr_we),
        .sts_clr    (sts_clr),
        .raw_sts    (raw_sts),
        .irq        (irq),
        .trig       (trig)
    );
endmodule

// File: rtl/pwm_event_gen_chk.sv
module pwm_event_gen_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic             mode_down,
    input logic [CNT_W-1:0] load_val,
    input logic             cfg_we,
    input logic             sts_clr_we,
    input logic [5:0]       raw_sts,
    input logic             irq,
    input logic             trig,
    input logic [CNT_W-1:0] cnt
);
    // R3
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(cnt));

    // R2
    sawtooth_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_down && run && cnt == '0) |=> (cnt == $past(load_val)));

    // R8
    trig_needs_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig |-> $past(run));

    // R9
    sts_set_needs_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((raw_sts & ~$past(raw_sts)) != 6'b0) |-> $past(run));

    // R9
    sts_fall_needs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(raw_sts) & ~raw_sts) != 6'b0) |-> $past(sts_clr_we));

    // R10
    irq_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(run) || $past(cfg_we)));
endmodule

bind pwm_event_gen pwm_event_gen_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .mode_down  (mode_down),
    .load_val   (load_val),
    .cfg_we     (cfg_we),
    .sts_clr_we (sts_clr_we),
    .raw_sts    (raw_sts),
    .irq        (irq),
    .trig       (trig),
    .cnt        (cnt)
);

// File: tb/test_pwm_event_gen.sv
`timescale 1ns/1ps
module test_pwm_event_gen;
    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             run;
    logic             mode_down;
    logic [CNT_W-1:0] load_val, cmp_a, cmp_b;
    logic             cfg_we;
    logic [31:0]      cfg_wdata, cfg_rdata;
    logic             sts_clr_we;
    logic [5:0]       sts_clr, raw_sts;
    logic             irq, trig, cnt_up;
    logic [CNT_W-1:0] cnt;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // model state
    int        m_p;
    logic [5:0] m_sts, m_ien, m_ten;

    always #2.5 clk = ~clk;

    pwm_event_gen #(.CNT_W(CNT_W)) i_pwm_event_gen (
        .clk(clk), .rst_n(rst_n), .run(run), .mode_down(mode_down),
        .load_val(load_val), .cmp_a(cmp_a), .cmp_b(cmp_b),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .sts_clr_we(sts_clr_we), .sts_clr(sts_clr), .raw_sts(raw_sts),
        .irq(irq), .trig(trig), .cnt(cnt), .cnt_up(cnt_up)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int mdl_cnt(int L, bit md, int p);
        if (md) return L - ((p + L) % (L + 1));
        if (L == 0) return 0;
        begin
            int q = p % (2 * L);
            return (q <= L) ? q : 2 * L - q;
        end
    endfunction

    function automatic bit mdl_up(int L, bit md, int p);
        if (md) return 1'b0;
        if (L == 0) return 1'b1;
        return (p % (2 * L)) < L;
    endfunction

    task automatic do_reset(input bit md);
        @(negedge clk);
        rst_n = 1'b0; run = 1'b0; mode_down = md;
        cfg_we = 1'b0; sts_clr_we = 1'b0; sts_clr = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_p = 0; m_sts = '0; m_ien = '0; m_ten = '0;
    endtask

    task automatic wr_cfg(input logic [31:0] d);
        cfg_we = 1'b1; cfg_wdata = d;
        @(posedge clk); @(negedge clk);
        cfg_we = 1'b0;
        m_ien = d[5:0]; m_ten = d[13:8];
    endtask

    task automatic run_cfg(input int L, input int A, input bit md, input int k);
        logic [5:0] ev, clr;
        int c;
        bit u;
        do_reset(md);
        load_val = CNT_W'(L); cmp_a = CNT_W'(A); cmp_b = CNT_W'(L - A);
        case (k)
            0:       wr_cfg(32'h0000_3F3F);
            1:       wr_cfg(32'h0000_2A15);
            default: wr_cfg(32'h0000_152A);
        endcase
        for (int s = 0; s < 2 * L + 3; s++) begin
            c  = mdl_cnt(L, md, m_p);
            u  = mdl_up(L, md, m_p);
            ev = '0;
            ev[0] = (c == 0);
            ev[1] = (c == L);
            ev[2] = (c == A) && u;
            ev[3] = (c == A) && !u;
            ev[4] = (c == L - A) && u;
            ev[5] = (c == L - A) && !u;
            clr = (s % 4 == 3) ? 6'h3F : 6'h00;
            run = 1'b1; sts_clr_we = (clr != 0); sts_clr = clr;
            @(posedge clk); @(negedge clk);
            sts_clr_we = 1'b0;
            m_p++;
            m_sts = (m_sts & ~clr) | (ev & m_ien);
            chk(cnt == CNT_W'(mdl_cnt(L, md, m_p)), md ? "R2 count" : "R1 count",
                32'(cnt), 32'(mdl_cnt(L, md, m_p)));
            chk(cnt_up == mdl_up(L, md, m_p), md ? "R2 dir" : "R1 dir",
                32'(cnt_up), 32'(mdl_up(L, md, m_p)));
            chk(trig == |(ev & m_ten), "R4 R6 R8 trig", 32'(trig), 32'(|(ev & m_ten)));
            chk(raw_sts == m_sts, "R4 R5 R9 status", 32'(raw_sts), 32'(m_sts));
            chk(irq == |m_sts, "R10 irq", 32'(irq), 32'(|m_sts));
        end
        run = 1'b0;
    endtask

    initial begin
        cfg_wdata = '0; load_val = '0; cmp_a = '0; cmp_b = '0;
        do_reset(1'b0);
        // reset state
        chk(cnt == '0, "R1 reset count", 32'(cnt), 0);
        chk(cnt_up == 1'b1, "R1 reset dir", 32'(cnt_up), 1);
        chk(cfg_rdata == 32'h0, "R7 reset enables", cfg_rdata, 0);
        chk(trig == 1'b0, "R8 reset trig", 32'(trig), 0);
        chk(irq == 1'b0 && raw_sts == '0, "R10 reset irq", {irq, 26'b0, raw_sts}, 0);

        // reserved bits ignored
        wr_cfg(32'hFFFF_FFFF);
        chk(cfg_rdata == 32'h0000_3F3F, "R7 reserved readback", cfg_rdata, 32'h3F3F);
        wr_cfg(32'h0000_0C21);
        chk(cfg_rdata == 32'h0000_0C21, "R5 R6 field readback", cfg_rdata, 32'h0C21);
        wr_cfg(32'h0000_3F3F);

        // idle: nothing moves
        load_val = 8'd4; cmp_a = 8'd0; cmp_b = 8'd0;
        repeat (5) @(negedge clk);
        chk(cnt == '0, "R3 hold count", 32'(cnt), 0);
        chk(trig == 1'b0, "R3 no trig", 32'(trig), 0);
        chk(raw_sts == '0, "R3 no status", 32'(raw_sts), 0);

        // sweep
        for (int md = 0; md < 2; md++)
            for (int L = 0; L <= 5; L++)
                for (int A = 0; A <= L; A++)
                    for (int k = 0; k < 3; k++)
                        run_cfg(L, A, md[0], k);

        // masking of the interrupt line
        do_reset(1'b0);
        load_val = 8'd3; cmp_a = 8'd1; cmp_b = 8'd2;
        wr_cfg(32'h0000_0001);
        run = 1'b1; @(posedge clk); @(negedge clk); run = 1'b0;
        chk(raw_sts == 6'h01 && irq, "R9 zero event latched", {irq, 26'b0, raw_sts}, 32'h8000_0001);
        repeat (3) @(negedge clk);
        chk(raw_sts == 6'h01, "R9 sticky", 32'(raw_sts), 1);
        wr_cfg(32'h0000_0000);
        chk(irq == 1'b0, "R10 masked irq", 32'(irq), 0);
        chk(raw_sts == 6'h01, "R10 status kept", 32'(raw_sts), 1);
        wr_cfg(32'h0000_0001);
        chk(irq == 1'b1, "R10 unmasked irq", 32'(irq), 1);
        sts_clr_we = 1'b1; sts_clr = 6'h3E;
        @(posedge clk); @(negedge clk);
        chk(raw_sts == 6'h01, "R9 clear other bits", 32'(raw_sts), 1);
        sts_clr = 6'h01;
        @(posedge clk); @(negedge clk);
        sts_clr_we = 1'b0;
        chk(raw_sts == 6'h00 && !irq, "R9 clear bit", {irq, 26'b0, raw_sts}, 0);

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule